// File: doc/BRIEF.md
# VLAN Table Engine with Indirect Command Access

This block keeps a table of per-VLAN forwarding entries. Software cannot address the table directly. It loads two data words, then writes a command word that names a VLAN ID and a function. The engine then copies one entry between the table and the data words. The busy flag in the command word stays set for a fixed number of cycles. After it clears, software reads the invalid flag to learn whether the command was rejected.

Each entry holds:
- a valid flag;
- an independent-learning flag;
- a per-VLAN egress-tag enable;
- a port membership mask;
- a two-bit egress tagging code for every port.

The tagging codes are: 0 sends frames untagged, 2 sends them tagged, and 3 stacks the VLAN tag after the switch's internal header. A separate lookup port gives the forwarding path the membership and tagging of any VLAN ID, one cycle after the ID is presented.

The register bus is a simple word-addressed port:
- address 0 is the command word;
- address 1 is data word 1;
- address 2 is data word 2;
- address 3 reads zero.

A write takes effect on the clock edge where `bus_we` is high, and reads are combinational.

Top module: `vlan_tbl_engine`

## Requirements
- R1: After reset, every register reads zero: busy and invalid are clear, both data words are zero, and every lookup misses.
- R2: A command-word write with bit 31 set, made while idle, is accepted. Busy (bit 31) reads 1 for exactly LAT cycles, starting the cycle after the write. The command word then reports the accepted function in bits 15:12 and the VLAN ID in bits 11:0. Bits 30:17 and bits 15:0 other than these fields read zero.
- R3: While busy is set, bus writes to the command word and to both data words are ignored.
- R4: A command-word write with bit 31 clear has no effect.
- R5: Function 0 (read) loads the selected entry into the data words, when the entry is valid. Data word 1 carries independent learning at bit 30, the egress-tag enable at bit 28, the membership mask at bits 16+NPORT-1:16 and the valid flag at bit 0; all other bits read zero. Data word 2 carries port p's tagging code at bits 2p+1:2p (0 untagged, 2 tagged, 3 stack), with the upper bits zero.
- R6: Function 1 (write) stores the data words into the selected entry; bit 0 of data word 1 becomes the valid flag. The data words keep their values.
- R7: Any function code other than 0 or 1 leaves the table and the data words unchanged, and sets the invalid flag (bit 16) when busy clears. The next accepted command clears the flag.
- R8: A command whose VLAN ID is at or above TBL_DEPTH sets the invalid flag and changes neither the table nor the data words.
- R9: A read of an entry whose valid flag is clear, including one never written, loads zero into both data words.
- R10: Writing all-zero data words into an entry invalidates it, and later lookups of that ID miss.
- R11: One cycle after `lk_vid` is presented, `lk_hit` is 1 and the entry's fields appear on the lookup outputs, if the ID is in range and the entry is valid. Otherwise `lk_hit` and all the lookup fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 command, 1 data word 1, 2 data word 2 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| lk_vid | input | 12 | VLAN ID to look up |
| lk_hit | output | 1 | Looked-up entry is in range and valid |
| lk_members | output | NPORT | Port membership mask of the entry |
| lk_etag | output | 2*NPORT | Per-port egress tagging codes |
| lk_ivl | output | 1 | Independent learning flag |
| lk_etag_en | output | 1 | Per-VLAN egress tag enable |

## Verification
The bench builds the engine with TBL_DEPTH = 48, LAT = 3 and NPORT = 8. Because the depth is not a power of two, six-bit random VLAN IDs land both inside the table and in the 48..63 band. That band decodes to an index but must be rejected, so one random stream exercises the out-of-range rejection on commands and lookups. A short latency keeps busy windows small, so many random read, write and bad-function commands fit in the run. The busy-cycle count is still checked exactly on each one.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int VID_W      = 12;
  localparam int CMD_BUSY   = 31;
  localparam int CMD_INV    = 16;
  localparam int CMD_FN_LSB = 12;
  localparam int W1_IVL     = 30;
  localparam int W1_TEN     = 28;
  localparam int W1_MEM_LSB = 16;
  localparam int W1_VLD     = 0;

  localparam logic [1:0] RA_CMD   = 2'd0;
  localparam logic [1:0] RA_DATA1 = 2'd1;
  localparam logic [1:0] RA_DATA2 = 2'd2;

  localparam logic [3:0] FN_READ  = 4'd0;
  localparam logic [3:0] FN_WRITE = 4'd1;
endpackage

// File: rtl/vtbl_cmd_ctrl.sv
module vtbl_cmd_ctrl
  import vtbl_pkg::*;
#(
  parameter int TBL_DEPTH = 1024,
  parameter int LAT       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  output logic             busy,
  output logic             invalid,
  output logic [3:0]       func,
  output logic [VID_W-1:0] vid,
  output logic             done_rd,
  output logic             done_wr
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [VID_W:0] LIMIT = (VID_W + 1)'(TBL_DEPTH);
  localparam logic [CW-1:0]  LAST_CNT = CW'(LAT - 1);

  logic             busy_q, busy_d;
  logic             inv_q, inv_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [3:0]       fn_q, fn_d;
  logic [VID_W-1:0] vid_q, vid_d;
  logic             start, last, in_range, fn_ok;
  logic             unused_cmd_bits;

  assign unused_cmd_bits = ^cmd_wdata[30:16];

  assign start    = cmd_we && cmd_wdata[CMD_BUSY] && !busy_q;
  assign last     = busy_q && (cnt_q == LAST_CNT);
  assign in_range = {1'b0, vid_q} < LIMIT;
  assign fn_ok    = (fn_q == FN_READ) || (fn_q == FN_WRITE);
  assign done_rd  = last && in_range && (fn_q == FN_READ);
  assign done_wr  = last && in_range && (fn_q == FN_WRITE);

  always_comb begin
    busy_d = busy_q;
    inv_d  = inv_q;
    cnt_d  = cnt_q;
    fn_d   = fn_q;
    vid_d  = vid_q;
    if (start) begin
      busy_d = 1'b1;
      inv_d  = 1'b0;
      cnt_d  = '0;
      fn_d   = cmd_wdata[CMD_FN_LSB +: 4];
      vid_d  = cmd_wdata[VID_W-1:0];
    end else if (last) begin
      busy_d = 1'b0;
      inv_d  = !(fn_ok && in_range);
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      inv_q  <= 1'b0;
      cnt_q  <= '0;
      fn_q   <= '0;
      vid_q  <= '0;
    end else begin
      busy_q <= busy_d;
      inv_q  <= inv_d;
      cnt_q  <= cnt_d;
      fn_q   <= fn_d;
      vid_q  <= vid_d;
    end
  end

  assign busy    = busy_q;
  assign invalid = inv_q;
  assign func    = fn_q;
  assign vid     = vid_q;

  // R2: busy only rises from an accepted command write
  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cmd_we && cmd_wdata[CMD_BUSY]));
  // R2: busy window ends only after the full latency
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST_CNT));
  // R3: command fields held while busy
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_we) |=> ($stable(fn_q) && $stable(vid_q)));
  // R7: invalid only raised as a command completes
  assert_inv_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_q) |-> $fell(busy_q));
endmodule

// File: rtl/vtbl_data_regs.sv
module vtbl_data_regs
  import vtbl_pkg::*;
#(
  parameter int NPORT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               we1,
  input  logic               we2,
  input  logic [31:0]        wdata,
  input  logic               ld_rd,
  input  logic               rd_valid,
  input  logic [3*NPORT+1:0] rd_ent,
  output logic [31:0]        word1,
  output logic [31:0]        word2,
  output logic               wr_valid,
  output logic [3*NPORT+1:0] wr_ent
);
  localparam int ET_W = 2 * NPORT;
  localparam logic [31:0] M1 = (32'(1) << W1_IVL) | (32'(1) << W1_TEN) |
                               (((32'(1) << NPORT) - 32'(1)) << W1_MEM_LSB) |
                               (32'(1) << W1_VLD);
  localparam logic [31:0] M2 = (32'(1) << ET_W) - 32'(1);

  logic [31:0] w1_q, w1_d, w2_q, w2_d;
  logic [31:0] rd_w1, rd_w2;

  always_comb begin
    rd_w1 = '0;
    rd_w2 = '0;
    if (rd_valid) begin
      rd_w1[W1_IVL]                 = rd_ent[3*NPORT+1];
      rd_w1[W1_TEN]                 = rd_ent[3*NPORT];
      rd_w1[W1_MEM_LSB +: NPORT]    = rd_ent[ET_W +: NPORT];
      rd_w1[W1_VLD]                 = 1'b1;
      rd_w2[ET_W-1:0]               = rd_ent[ET_W-1:0];
    end
  end

  always_comb begin
    w1_d = w1_q;
    w2_d = w2_q;
    if (ld_rd) begin
      w1_d = rd_w1;
      w2_d = rd_w2;
    end else if (!busy) begin
      if (we1) w1_d = wdata & M1;
      if (we2) w2_d = wdata & M2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
      w2_q <= '0;
    end else begin
      w1_q <= w1_d;
      w2_q <= w2_d;
    end
  end

  assign word1    = w1_q;
  assign word2    = w2_q;
  assign wr_valid = w1_q[W1_VLD];
  assign wr_ent   = {w1_q[W1_IVL], w1_q[W1_TEN], w1_q[W1_MEM_LSB +: NPORT], w2_q[ET_W-1:0]};

  // R3: bus writes during busy leave the data words alone
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_rd) |=> ($stable(w1_q) && $stable(w2_q)));
  // R9: loaded data word 1 is zero whenever its valid bit is zero
  assert_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rd && !rd_valid) |=> (w1_q == '0 && w2_q == '0));
endmodule

// File: rtl/vtbl_store.sv
module vtbl_store
  import vtbl_pkg::*;
#(
  parameter int TBL_DEPTH = 1024,
  parameter int NPORT     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [VID_W-1:0]   cmd_vid,
  input  logic               wr_valid,
  input  logic [3*NPORT+1:0] wr_ent,
  output logic               rd_valid,
  output logic [3*NPORT+1:0] rd_ent,
  input  logic [VID_W-1:0]   lk_vid,
  output logic               lk_hit,
  output logic [3*NPORT+1:0] lk_ent
);
  localparam int ENT_W = 3 * NPORT + 2;
  localparam int AW    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
  localparam logic [VID_W:0] LIMIT = (VID_W + 1)'(TBL_DEPTH);

  logic [ENT_W-1:0]     mem_q [TBL_DEPTH];
  logic [TBL_DEPTH-1:0] vld_q, vld_d;
  logic [AW-1:0]        cmd_idx, lk_idx;
  logic                 lk_in_range;
  logic                 lk_hit_q, lk_hit_d;
  logic [ENT_W-1:0]     lk_ent_q, lk_ent_d;

  assign cmd_idx     = cmd_vid[AW-1:0];
  assign lk_idx      = lk_vid[AW-1:0];
  assign lk_in_range = {1'b0, lk_vid} < LIMIT;

  assign rd_valid = vld_q[cmd_idx];
  assign rd_ent   = mem_q[cmd_idx];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[cmd_idx] = wr_valid;
  end

  always_comb begin
    lk_hit_d = lk_in_range && vld_q[lk_idx];
    lk_ent_d = lk_hit_d ? mem_q[lk_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      lk_hit_q <= 1'b0;
      lk_ent_q <= '0;
    end else begin
      vld_q    <= vld_d;
      lk_hit_q <= lk_hit_d;
      lk_ent_q <= lk_ent_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[cmd_idx] <= wr_ent;
  end

  assign lk_hit = lk_hit_q;
  assign lk_ent = lk_ent_q;

  // R8: the sequencer never writes an out-of-range row
  assert_wr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, cmd_vid} < LIMIT));
  // R11: a hit always follows an in-range lookup ID
  assert_hit_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit_q |-> $past({1'b0, lk_vid} < LIMIT));
endmodule

// File: rtl/vlan_tbl_engine.sv
module vlan_tbl_engine
  import vtbl_pkg::*;
#(
  parameter int TBL_DEPTH = 1024,
  parameter int LAT       = 4,
  parameter int NPORT     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [11:0]        lk_vid,
  output logic               lk_hit,
  output logic [NPORT-1:0]   lk_members,
  output logic [2*NPORT-1:0] lk_etag,
  output logic               lk_ivl,
  output logic               lk_etag_en
);
  localparam int ET_W  = 2 * NPORT;
  localparam int ENT_W = 3 * NPORT + 2;

  logic             busy, invalid, done_rd, done_wr;
  logic [3:0]       func;
  logic [VID_W-1:0] cmd_vid;
  logic [31:0]      word1, word2;
  logic             rd_valid, wr_valid;
  logic [ENT_W-1:0] rd_ent, wr_ent, lk_ent;

  vtbl_cmd_ctrl #(.TBL_DEPTH(TBL_DEPTH), .LAT(LAT)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(bus_we && (bus_addr == RA_CMD)), .cmd_wdata(bus_wdata),
    .busy(busy), .invalid(invalid), .func(func), .vid(cmd_vid),
    .done_rd(done_rd), .done_wr(done_wr)
  );

  vtbl_data_regs #(.NPORT(NPORT)) u_data (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .we1(bus_we && (bus_addr == RA_DATA1)),
    .we2(bus_we && (bus_addr == RA_DATA2)),
    .wdata(bus_wdata), .ld_rd(done_rd),
    .rd_valid(rd_valid), .rd_ent(rd_ent),
    .word1(word1), .word2(word2),
    .wr_valid(wr_valid), .wr_ent(wr_ent)
  );

  vtbl_store #(.TBL_DEPTH(TBL_DEPTH), .NPORT(NPORT)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(done_wr), .cmd_vid(cmd_vid),
    .wr_valid(wr_valid), .wr_ent(wr_ent),
    .rd_valid(rd_valid), .rd_ent(rd_ent),
    .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_ent(lk_ent)
  );

  always_comb begin
    unique case (bus_addr)
      RA_CMD:   bus_rdata = {busy, 14'd0, invalid, func, cmd_vid};
      RA_DATA1: bus_rdata = word1;
      RA_DATA2: bus_rdata = word2;
      default:  bus_rdata = '0;
    endcase
  end

  assign lk_ivl     = lk_ent[ENT_W-1];
  assign lk_etag_en = lk_ent[ENT_W-2];
  assign lk_members = lk_ent[ET_W +: NPORT];
  assign lk_etag    = lk_ent[ET_W-1:0];

  // R11: a missed lookup drives no membership
  assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_members == '0 && lk_etag == '0));
endmodule

// File: tb/vlan_tbl_engine_tb.sv
module vlan_tbl_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 48;
  localparam int LATC  = 3;
  localparam int NP    = 8;
  localparam logic [31:0] M1 = 32'h50FF_0001;
  localparam logic [31:0] M2 = 32'h0000_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] lk_vid = '0;
  logic        lk_hit;
  logic [NP-1:0]   lk_members;
  logic [2*NP-1:0] lk_etag;
  logic        lk_ivl, lk_etag_en;

  int n_chk = 0;
  int n_bad = 0;

  logic        m_vld [64];
  logic [31:0] m_w1 [64];
  logic [31:0] m_w2 [64];
  logic [31:0] md1 = '0, md2 = '0;
  logic        m_inv = 1'b0;
  logic [3:0]  m_fn = '0;
  logic [11:0] m_vid = '0;

  vlan_tbl_engine #(.TBL_DEPTH(DEPTH), .LAT(LATC), .NPORT(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_vid(lk_vid),
    .lk_hit(lk_hit), .lk_members(lk_members), .lk_etag(lk_etag),
    .lk_ivl(lk_ivl), .lk_etag_en(lk_etag_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd_word(logic inv, logic [3:0] fn, logic [11:0] vid);
    return {1'b0, 14'd0, inv, fn, vid};
  endfunction

  task automatic rd_reg(logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // model of one completed command
  task automatic model_cmd(logic [3:0] fn, logic [11:0] vid);
    logic ok;
    ok = (fn <= 4'd1) && (vid < 12'(DEPTH));
    m_fn = fn; m_vid = vid; m_inv = !ok;
    if (ok && fn == 4'd1) begin
      m_vld[vid[5:0]] = md1[0];
      m_w1[vid[5:0]]  = md1;
      m_w2[vid[5:0]]  = md2;
    end else if (ok && fn == 4'd0) begin
      md1 = m_vld[vid[5:0]] ? m_w1[vid[5:0]] : '0;
      md2 = m_vld[vid[5:0]] ? m_w2[vid[5:0]] : '0;
    end
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd_reg(2'd0, v);
    while (v[31]) begin
      cyc++;
      @(negedge clk);
      rd_reg(2'd0, v);
    end
  endtask

  task automatic run_cmd(logic [3:0] fn, logic [11:0] vid, string tag);
    int cyc;
    logic [31:0] v;
    wr_reg(2'd0, {1'b1, 15'd0, fn, vid});
    wait_idle(cyc);
    chk({tag, " R2 busy cycles"}, 32'(cyc), 32'(LATC));
    model_cmd(fn, vid);
    rd_reg(2'd0, v); chk({tag, " R2 R7 R8 cmd word"}, v, cmd_word(m_inv, m_fn, m_vid));
    rd_reg(2'd1, v); chk({tag, " R5 R6 R9 data1"}, v, md1);
    rd_reg(2'd2, v); chk({tag, " R5 R6 R9 data2"}, v, md2);
  endtask

  task automatic lk_check(logic [11:0] vid, string tag);
    logic hit;
    logic [31:0] e1, e2;
    @(negedge clk);
    lk_vid = vid;
    @(negedge clk);
    hit = (vid < 12'(DEPTH)) && m_vld[vid[5:0]];
    e1 = hit ? m_w1[vid[5:0]] : '0;
    e2 = hit ? m_w2[vid[5:0]] : '0;
    chk({tag, " R11 hit"}, 32'(lk_hit), 32'(hit));
    chk({tag, " R11 fields"}, {lk_ivl, lk_etag_en, 6'd0, lk_members, lk_etag},
        {e1[30], e1[28], 6'd0, e1[23:16], e2[15:0]});
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int cyc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      m_vld[i] = 1'b0; m_w1[i] = '0; m_w2[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, v); chk("R1 cmd", v, '0);
    rd_reg(2'd1, v); chk("R1 data1", v, '0);
    rd_reg(2'd2, v); chk("R1 data2", v, '0);
    lk_check(12'd0, "R1");
    lk_check(12'd7, "R1");

    // R4 command without start bit
    wr_reg(2'd0, 32'h0000_1005);
    rd_reg(2'd0, v); chk("R4 no start", v, '0);

    // R9 read of never-written entry
    wr_reg(2'd1, 32'hFFFF_FFFF); md1 = M1;
    wr_reg(2'd2, 32'hFFFF_FFFF); md2 = M2;
    run_cmd(4'd0, 12'd3, "R9 fresh read");

    // R5 R6 stack code on the top port, tagged on port 0, untagged port 1
    wr_reg(2'd1, 32'h5081_0001); md1 = 32'h5081_0001;
    wr_reg(2'd2, 32'hC002);      md2 = 32'h0000_C002;
    run_cmd(4'd1, 12'd10, "R6 write");
    lk_check(12'd10, "R5 R6");
    wr_reg(2'd1, 32'h0); md1 = '0;
    wr_reg(2'd2, 32'h0); md2 = '0;
    run_cmd(4'd0, 12'd10, "R5 read");

    // R7 bad function, then cleared by next command
    run_cmd(4'd5, 12'd10, "R7 bad fn");
    run_cmd(4'd0, 12'd10, "R7 clear");

    // R8 out of range
    run_cmd(4'd1, 12'd50, "R8 write high");
    run_cmd(4'd0, 12'd4095, "R8 read high");
    lk_check(12'd50, "R8");

    // R3 writes during busy are ignored
    wr_reg(2'd1, 32'h1002_0001); md1 = 32'h1002_0001;
    wr_reg(2'd2, 32'h0000_0030); md2 = 32'h0000_0030;
    @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = {1'b1, 15'd0, 4'd1, 12'd5};
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = {1'b1, 15'd0, 4'd0, 12'd9};
    @(negedge clk);
    bus_we = 1'b0;
    wait_idle(cyc);
    model_cmd(4'd1, 12'd5);
    rd_reg(2'd0, v); chk("R3 cmd kept", v, cmd_word(1'b0, 4'd1, 12'd5));
    rd_reg(2'd1, v); chk("R3 data1 kept", v, md1);
    lk_check(12'd5, "R3");

    // R10 zero data invalidates
    wr_reg(2'd1, 32'h0); md1 = '0;
    wr_reg(2'd2, 32'h0); md2 = '0;
    run_cmd(4'd1, 12'd10, "R10 clear");
    lk_check(12'd10, "R10");

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [3:0]  fn;
      logic [11:0] vid;
      int sel;
      sel = $urandom_range(0, 9);
      fn = (sel < 4) ? 4'd1 : (sel < 8) ? 4'd0 : 4'($urandom_range(2, 15));
      vid = 12'($urandom_range(0, 63));
      if (fn == 4'd1) begin
        v = $urandom;
        if ($urandom_range(0, 3) == 0) v = '0;
        wr_reg(2'd1, v); md1 = v & M1;
        v = $urandom;
        wr_reg(2'd2, v); md2 = v & M2;
      end
      run_cmd(fn, vid, "rand");
      lk_check(12'($urandom_range(0, 63)), "rand");
    end

    finish_run();
  end
endmodule